// File: doc/BRIEF.md
# Threshold Trigger Comparator

This block watches a stream of unsigned sample codes and turns it into one digital trigger. Each sample comes with a valid strobe. The block compares it against two programmable thresholds, a lower one and an upper one. A mode select sets how the two comparisons become the trigger, and there are five ways to do this. Three modes have no memory: below the lower bound, above the upper bound, and strictly between the two. The other two modes use hysteresis. In those, one threshold fires the trigger and the other threshold only releases it.

The decision is held in a state register. A registered output stage then drives a trigger level and a one-cycle pulse that marks each rise of that level. The block also checks the threshold pair. If the lower threshold is not strictly below the upper one, it raises a configuration error and keeps the trigger low. A global enable does the same thing when it is low: it forces the trigger inactive and clears any hysteresis memory. The sample width is a parameter, so the same block works with 8-bit codes, 12-bit codes or any other width.

Top module: `thresh_trigger`

## Requirements
- R1: While reset is high, and on the first clock edge after it, trig_level and trig_pulse are 0. cfg_err is 0 while reset is held.
- R2: The mode is a 3-bit code: 0 below-low, 1 above-high, 2 inside-window, 3 high-side hysteresis, 4 low-side hysteresis. Codes 5, 6 and 7 keep trig_level at 0 and clear the decision state.
- R3: In mode 0 a valid sample sets the trigger when sample < thr_lo and clears it otherwise. thr_hi plays no part in the decision.
- R4: In mode 1 a valid sample sets the trigger when sample > thr_hi and clears it otherwise. thr_lo plays no part in the decision.
- R5: In mode 2 a valid sample sets the trigger when thr_lo < sample < thr_hi. The comparison is strict, so a sample equal to either bound clears the trigger.
- R6: In mode 3 a valid sample with sample > thr_hi sets the trigger, and one with sample < thr_lo clears it. Any other sample leaves the trigger unchanged.
- R7: In mode 4 a valid sample with sample < thr_lo sets the trigger, and one with sample > thr_hi clears it. Any other sample leaves the trigger unchanged.
- R8: cfg_err is 1 one clock edge after thr_lo >= thr_hi is presented, and 0 one edge after a valid pair (thr_lo < thr_hi) is presented. While the pair is invalid, trig_level is 0 and the hysteresis state is cleared, so a later in-band sample does not bring the trigger back.
- R9: When enable is low, trig_level is 0 from the next clock edge and the hysteresis state is cleared.
- R10: A sample presented with samp_valid low has no effect on the trigger.
- R11: A valid sample taken at clock edge k is reflected on trig_level after edge k+1. trig_pulse is 1 for exactly the one cycle in which trig_level has just gone from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | On/off control for the trigger |
| mode | input | 3 | Trigger mode code |
| thr_lo | input | SAMPLE_W | Lower threshold code |
| thr_hi | input | SAMPLE_W | Upper threshold code |
| samp | input | SAMPLE_W | Sample code |
| samp_valid | input | 1 | Sample strobe |
| trig_level | output | 1 | Registered trigger level |
| trig_pulse | output | 1 | One-cycle pulse on each rise of the trigger |
| cfg_err | output | 1 | Threshold pair invalid (thr_lo >= thr_hi) |

## Verification
The bench uses a 4-bit instance and walks every ordered threshold pair in every mode code, including the three unused codes and the pairs with thr_lo >= thr_hi. For the stateless modes it applies an ascending ramp of all sample codes, which shows that each comparison switches at exactly the right code and that equal-to-bound samples are handled strictly. For the hysteresis modes it applies a full up-then-down triangle, so that the dead band between the thresholds is crossed in both directions: the trigger must hold there on the way up and on the way down, which separates the hysteresis behaviour from a plain comparator. Directed sequences then cover the remaining behaviours one by one: an invalid sample is ignored, dropping enable or entering a bad threshold pair wipes the hysteresis memory, and the output follows the exact two-edge latency.

// File: rtl/thresh_trigger_pkg.sv
package thresh_trigger_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_BELOW   = 3'd0,
        MODE_ABOVE   = 3'd1,
        MODE_INSIDE  = 3'd2,
        MODE_HYST_HI = 3'd3,
        MODE_HYST_LO = 3'd4
    } trig_mode_e;

    // Comparison flags of one sample against both thresholds
    typedef struct packed {
        logic lt_lo;
        logic gt_lo;
        logic lt_hi;
        logic gt_hi;
    } cmp_flags_t;

    // Per-sample decision request for the state register
    typedef struct packed {
        logic set;
        logic clr;
    } trig_req_t;

    function automatic logic mode_known(logic [MODE_W-1:0] m);
        return m <= MODE_HYST_LO;
    endfunction

    function automatic trig_req_t decide(trig_mode_e m, cmp_flags_t f);
        trig_req_t r;
        r = '{set: 1'b0, clr: 1'b0};
        case (m)
            MODE_BELOW:   begin r.set = f.lt_lo;           r.clr = ~f.lt_lo;              end
            MODE_ABOVE:   begin r.set = f.gt_hi;           r.clr = ~f.gt_hi;              end
            MODE_INSIDE:  begin r.set = f.gt_lo & f.lt_hi; r.clr = ~(f.gt_lo & f.lt_hi);  end
            MODE_HYST_HI: begin r.set = f.gt_hi;           r.clr = f.lt_lo;               end
            MODE_HYST_LO: begin r.set = f.lt_lo;           r.clr = f.gt_hi;               end
            default:      begin r.set = 1'b0;              r.clr = 1'b1;                  end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trig_cfg_check.sv
module trig_cfg_check #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] thr_lo,
    input  logic [W-1:0] thr_hi,
    output logic         cfg_bad,
    output logic         cfg_err_q
);
    // The pair is valid only when the lower bound is strictly below the upper one
    assign cfg_bad = (thr_lo >= thr_hi);

    always_ff @(posedge clk) begin
        if (rst) cfg_err_q <= 1'b0;
        else     cfg_err_q <= cfg_bad;
    end
endmodule

// File: rtl/trig_eval.sv
module trig_eval
    import thresh_trigger_pkg::*;
#(
    parameter int W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      samp,
    input  logic              samp_valid,
    input  logic [W-1:0]      thr_lo,
    input  logic [W-1:0]      thr_hi,
    input  logic [MODE_W-1:0] mode,
    input  logic              gate_ok,
    output logic              hold_q
);
    cmp_flags_t flags;
    trig_req_t  req;
    trig_mode_e mode_e;

    assign mode_e = trig_mode_e'(mode);

    always_comb begin
        flags.lt_lo = samp < thr_lo;
        flags.gt_lo = samp > thr_lo;
        flags.lt_hi = samp < thr_hi;
        flags.gt_hi = samp > thr_hi;
        req         = decide(mode_e, flags);
    end

    always_ff @(posedge clk) begin
        if (rst || !gate_ok) begin
            hold_q <= 1'b0;
        end else if (samp_valid) begin
            if (req.set)      hold_q <= 1'b1;
            else if (req.clr) hold_q <= 1'b0;
        end
    end
endmodule

// File: rtl/trig_out_stage.sv
module trig_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic gate_ok,
    output logic trig_level,
    output logic trig_pulse
);
    logic level_d;

    assign level_d = hold & gate_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_level <= 1'b0;
            trig_pulse <= 1'b0;
        end else begin
            trig_level <= level_d;
            trig_pulse <= level_d & ~trig_level;
        end
    end
endmodule

// File: rtl/thresh_trigger.sv
module thresh_trigger
    import thresh_trigger_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [2:0]          mode,
    input  logic [SAMPLE_W-1:0] thr_lo,
    input  logic [SAMPLE_W-1:0] thr_hi,
    input  logic [SAMPLE_W-1:0] samp,
    input  logic                samp_valid,
    output logic                trig_level,
    output logic                trig_pulse,
    output logic                cfg_err
);
    logic cfg_bad;
    logic gate_ok;
    logic hold;

    trig_cfg_check #(.W(SAMPLE_W)) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .cfg_bad   (cfg_bad),
        .cfg_err_q (cfg_err)
    );

    assign gate_ok = enable & ~cfg_bad & mode_known(mode);

    trig_eval #(.W(SAMPLE_W)) eval_i (
        .clk        (clk),
        .rst        (rst),
        .samp       (samp),
        .samp_valid (samp_valid),
        .thr_lo     (thr_lo),
        .thr_hi     (thr_hi),
        .mode       (mode),
        .gate_ok    (gate_ok),
        .hold_q     (hold)
    );

    trig_out_stage out_i (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .gate_ok    (gate_ok),
        .trig_level (trig_level),
        .trig_pulse (trig_pulse)
    );
endmodule

// File: rtl/thresh_trigger_chk.sv
module thresh_trigger_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic [2:0] mode,
    input logic       cfg_err,
    input logic       trig_level,
    input logic       trig_pulse
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R11: a pulse marks exactly a 0 -> 1 step of the level
    p_pulse_on_rise_r11: assert property (@(posedge clk) disable iff (rst || !past_ok)
        trig_pulse == (trig_level && !$past(trig_level)));

    // R8: an invalid threshold pair keeps the trigger low
    p_cfg_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !trig_level);

    // R9: enable low forces the trigger low at the next edge
    p_disable_low_r9: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$past(enable) |-> !trig_level);

    // R2: an unused mode code keeps the trigger low
    p_bad_mode_low_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(mode) > 3'd4) |-> !trig_level);

    // R1: nothing is active on the first edge out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !past_ok |-> (!trig_level && !trig_pulse));
endmodule

bind thresh_trigger thresh_trigger_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .mode       (mode),
    .cfg_err    (cfg_err),
    .trig_level (trig_level),
    .trig_pulse (trig_pulse)
);

// File: tb/thresh_trigger_tb_top.sv
module thresh_trigger_tb_top;
    localparam int W     = 4;
    localparam int NCODE = 1 << W;

    logic         clk = 1'b0;
    logic         rst;
    logic         enable;
    logic [2:0]   mode;
    logic [W-1:0] thr_lo, thr_hi, samp;
    logic         samp_valid;
    logic         trig_level, trig_pulse, cfg_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  st     = 1'b0;   // expected decision state
    bit  prev   = 1'b0;   // expected previous level

    always #5 clk = ~clk;

    thresh_trigger #(.SAMPLE_W(W)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .mode(mode),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .samp(samp), .samp_valid(samp_valid),
        .trig_level(trig_level), .trig_pulse(trig_pulse), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b (mode=%0d lo=%0d hi=%0d samp=%0d)",
                     req, what, act, exp, mode, thr_lo, thr_hi, samp);
        end
    endtask

    // Expected next state from the requirements
    function automatic bit model(int m, int lo, int hi, int s, bit cur);
        if (lo >= hi || m > 4) return 1'b0;
        case (m)
            0: return s < lo;
            1: return s > hi;
            2: return (s > lo) && (s < hi);
            3: return (s > hi) ? 1'b1 : ((s < lo) ? 1'b0 : cur);
            default: return (s < lo) ? 1'b1 : ((s > hi) ? 1'b0 : cur);
        endcase
    endfunction

    function automatic string req_of(int m, int lo, int hi);
        if (lo >= hi) return "R8";
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R2";
        endcase
    endfunction

    // Called at a negedge; returns at a negedge after the result is visible
    task automatic push(input int s, input string req);
        samp       = W'(s);
        samp_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        samp_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        st = model(int'(mode), int'(thr_lo), int'(thr_hi), s, st);
        chk(req, "level", trig_level, st);
        chk("R11", "pulse", trig_pulse, st & ~prev);
        chk("R8", "cfg_err", cfg_err, thr_lo >= thr_hi);
        prev = st;
    endtask

    task automatic setup(input int m, input int lo, input int hi);
        enable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        mode   = 3'(m);
        thr_lo = W'(lo);
        thr_hi = W'(hi);
        enable = 1'b1;
        st     = 1'b0;
        prev   = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b0; mode = 3'd0;
        thr_lo = '0; thr_hi = '0; samp = '0; samp_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "level in reset", trig_level, 1'b0);
        chk("R1", "pulse in reset", trig_pulse, 1'b0);
        chk("R1", "cfg_err in reset", cfg_err, 1'b0);
        rst = 1'b0;
        thr_lo = W'(2); thr_hi = W'(9);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "level after reset", trig_level, 1'b0);
        chk("R1", "pulse after reset", trig_pulse, 1'b0);

        // Sweep: every mode code, every threshold pair
        for (int m = 0; m < 8; m++) begin
            for (int lo = 0; lo < NCODE; lo++) begin
                for (int hi = 0; hi < NCODE; hi++) begin
                    setup(m, lo, hi);
                    for (int s = 0; s < NCODE; s++) push(s, req_of(m, lo, hi));
                    if (m == 3 || m == 4)
                        for (int s = NCODE - 1; s >= 0; s--) push(s, req_of(m, lo, hi));
                end
            end
        end

        // R11: exact latency of level and pulse
        setup(1, 2, 5);
        samp = W'(9); samp_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        samp_valid = 1'b0;
        chk("R11", "level one edge after sample", trig_level, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R11", "level two edges after sample", trig_level, 1'b1);
        chk("R11", "pulse on rise", trig_pulse, 1'b1);
        @(posedge clk); @(negedge clk);
        chk("R11", "pulse lasts one cycle", trig_pulse, 1'b0);
        chk("R11", "level holds", trig_level, 1'b1);

        // R10: samples without strobe are ignored
        setup(0, 5, 10);
        push(2, "R3");
        samp = W'(8);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "level unchanged by unstrobed sample", trig_level, 1'b1);

        // R9: disable drops the trigger and clears hysteresis
        setup(3, 4, 10);
        push(12, "R6");
        enable = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9", "level low when disabled", trig_level, 1'b0);
        enable = 1'b1;
        st = 1'b0; prev = 1'b0;
        push(7, "R9");

        // R8: a bad pair drops the trigger and clears hysteresis
        setup(4, 4, 10);
        push(1, "R7");
        thr_lo = W'(12);
        @(posedge clk); @(negedge clk);
        chk("R8", "level low on bad pair", trig_level, 1'b0);
        chk("R8", "cfg_err raised", cfg_err, 1'b1);
        thr_lo = W'(4);
        st = 1'b0; prev = 1'b0;
        push(7, "R8");

        done = 1'b1;
        finish_run();
    end
endmodule